// File: doc/BRIEF.md
# Branch Direction Predictor

This block supplies a taken or not-taken guess for conditional branches in an in-order pipeline. In the fetch stage the pipeline presents a branch address and its target, and in the same cycle the block returns a direction from combinational logic. When the branch resolves later, the pipeline sends back the branch address, the real outcome and the guess that was made for it. The block uses these to train its state and to count mispredictions.

A parameter picks one of four schemes. The first always returns one fixed direction. The second repeats the last outcome seen. The third guesses taken only for branches whose target lies below them. The fourth uses a two-bit saturating counter. The last-outcome and counter schemes keep state. That state is either a direct-mapped table indexed by low address bits, so each branch trains only its own slot, or a single slot that all branches share. A parameter also sets the state the block has after reset.

Two counters run alongside the predictor. One counts lookups and the other counts mispredicted resolutions. Both wrap at their width.

Top module: `branch_dir_pred`

## Requirements
- R1: In fixed mode the prediction is always bit 1 of INIT_STATE (1 = taken), and it does not change after any resolve.
- R2: In last-outcome mode the prediction equals the outcome of the most recent resolve that touched the slot. Before any resolve it equals bit 1 of INIT_STATE.
- R3: In target-compare mode the prediction is taken exactly when pred_target is lower than pred_pc as an unsigned number. Equal addresses predict not taken, and resolves have no effect.
- R4: In counter mode each slot holds 00 (strong not taken), 01 (weak not taken), 10 (weak taken) or 11 (strong taken), and bit 1 is the prediction. A taken resolve adds one, saturating at 11. A not-taken resolve subtracts one, saturating at 00.
- R5: Reset loads every slot with INIT_STATE and clears both counters.
- R6: With local history the slot index is pc[PC_LSB +: IDX_W]. Branches with different indices never affect each other, and branches with equal indices share a slot.
- R7: With global history a single slot serves every branch, whatever its address.
- R8: When a lookup and a resolve address the same slot in one cycle, the lookup returns the slot value from before that resolve. The update is visible from the next cycle.
- R9: pred_count goes up by one in the cycle after each cycle with pred_valid high, and holds otherwise.
- R10: mispred_count goes up by one in the cycle after each cycle with res_valid high and res_taken different from res_pred, and holds otherwise.
- R11: State changes only on cycles with res_valid high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pred_valid | input | 1 | A lookup is presented this cycle |
| pred_pc | input | PC_W | Address of the branch being looked up |
| pred_target | input | PC_W | Target address of that branch |
| pred_taken | output | 1 | Predicted direction, combinational from the lookup inputs |
| res_valid | input | 1 | A resolved branch is reported this cycle |
| res_pc | input | PC_W | Address of the resolved branch |
| res_taken | input | 1 | Actual outcome, 1 = taken |
| res_pred | input | 1 | Direction that was predicted for this branch |
| pred_count | output | CNT_W | Number of lookups, wrapping |
| mispred_count | output | CNT_W | Number of mispredicted resolutions, wrapping |

## Verification
The bench drives the same traffic into five configurations at once and compares each against a reference model. It pushes a counter up to 11 and down to 00 and keeps going. A counter that wraps instead of saturating would flip its prediction after the extra steps. It also resolves a branch whose index matches a branch at a different address. A table that indexed the wrong bits would either split the shared slot or merge separate ones. It issues lookups in the same cycle as resolves to the same slot, which catches a write-through that shows the new value one cycle early. Finally it drives target-compare lookups with equal addresses, where a less-or-equal comparison would predict taken.

// File: rtl/bp_pkg.sv
`timescale 1ns/1ps
package bp_pkg;

    typedef enum logic [1:0] {
        BP_FIXED = 2'd0,
        BP_LAST  = 2'd1,
        BP_BTFN  = 2'd2,
        BP_SAT2  = 2'd3
    } bp_mode_e;

    typedef logic [1:0] slot_t;

    // Saturating two-bit step: taken moves toward 11, not taken toward 00.
    function automatic slot_t sat2_step(input slot_t cur, input logic taken);
        slot_t nxt;
        nxt = cur;
        if (taken && (cur != 2'b11)) begin
            nxt = cur + 2'b01;
        end else if (!taken && (cur != 2'b00)) begin
            nxt = cur - 2'b01;
        end
        return nxt;
    endfunction

    // Last-outcome slot stores the outcome in both bits so bit 1 predicts.
    function automatic slot_t last_step(input logic taken);
        return {taken, taken};
    endfunction

endpackage

// File: rtl/bp_hist_table.sv
`timescale 1ns/1ps
module bp_hist_table
    import bp_pkg::*;
#(
    parameter int          IDX_W = 6,
    parameter int          DEPTH = 64,
    parameter logic [1:0]  INIT  = 2'b01
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output slot_t            rd_val,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    output slot_t            wr_cur,
    input  slot_t            wr_val
);

    generate
        if (DEPTH == 1) begin : g_shared
            slot_t one_d, one_q;

            always_comb begin
                one_d = one_q;
                if (wr_en) begin
                    one_d = wr_val;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    one_q <= INIT;
                end else begin
                    one_q <= one_d;
                end
            end

            assign rd_val = one_q;
            assign wr_cur = one_q;

            logic unused_idx;
            assign unused_idx = ^{rd_idx, wr_idx};
        end else begin : g_table
            slot_t [DEPTH-1:0] ent_d, ent_q;

            always_comb begin
                ent_d = ent_q;
                if (wr_en) begin
                    ent_d[wr_idx] = wr_val;
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    ent_q <= {DEPTH{INIT}};
                end else begin
                    ent_q <= ent_d;
                end
            end

            // Reads see the registered table, so a same-cycle write is not visible.
            assign rd_val = ent_q[rd_idx];
            assign wr_cur = ent_q[wr_idx];
        end
    endgenerate

endmodule

// File: rtl/bp_decide.sv
`timescale 1ns/1ps
module bp_decide
    import bp_pkg::*;
#(
    parameter bp_mode_e   MODE       = BP_SAT2,
    parameter logic [1:0] INIT_STATE = 2'b01,
    parameter int         PC_W       = 32
) (
    input  logic [PC_W-1:0] pc,
    input  logic [PC_W-1:0] target,
    input  slot_t           slot,
    output logic            taken
);

    logic backward;
    assign backward = (target < pc);

    generate
        if (MODE == BP_FIXED) begin : g_fixed
            logic unused_in;
            assign unused_in = ^{backward, slot};
            assign taken = INIT_STATE[1];
        end else if (MODE == BP_BTFN) begin : g_btfn
            logic unused_in;
            assign unused_in = ^slot;
            assign taken = backward;
        end else begin : g_state
            logic unused_in;
            assign unused_in = backward ^ slot[0];
            assign taken = slot[1];
        end
    endgenerate

endmodule

// File: rtl/bp_stats.sv
`timescale 1ns/1ps
module bp_stats #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lookup,
    input  logic             miss,
    output logic [CNT_W-1:0] lookups,
    output logic [CNT_W-1:0] misses
);

    typedef struct packed {
        logic [CNT_W-1:0] lookups;
        logic [CNT_W-1:0] misses;
    } stat_t;

    stat_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lookup) begin
            st_d.lookups = st_q.lookups + {{(CNT_W-1){1'b0}}, 1'b1};
        end
        if (miss) begin
            st_d.misses = st_q.misses + {{(CNT_W-1){1'b0}}, 1'b1};
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign lookups = st_q.lookups;
    assign misses  = st_q.misses;

endmodule

// File: rtl/branch_dir_pred.sv
`timescale 1ns/1ps
module branch_dir_pred
    import bp_pkg::*;
#(
    parameter bp_mode_e   MODE        = BP_SAT2,
    parameter bit         GLOBAL_HIST = 1'b0,
    parameter logic [1:0] INIT_STATE  = 2'b01,
    parameter int         PC_W        = 32,
    parameter int         IDX_W       = 6,
    parameter int         PC_LSB      = 2,
    parameter int         CNT_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pred_valid,
    input  logic [PC_W-1:0]  pred_pc,
    input  logic [PC_W-1:0]  pred_target,
    output logic             pred_taken,
    input  logic             res_valid,
    input  logic [PC_W-1:0]  res_pc,
    input  logic             res_taken,
    input  logic             res_pred,
    output logic [CNT_W-1:0] pred_count,
    output logic [CNT_W-1:0] mispred_count
);

    localparam bit KEEPS_STATE = (MODE == BP_LAST) || (MODE == BP_SAT2);
    localparam int DEPTH       = GLOBAL_HIST ? 1 : (1 << IDX_W);

    logic [IDX_W-1:0] rd_idx, wr_idx;
    slot_t            rd_slot, wr_cur, wr_new;
    logic             miss;

    assign rd_idx = GLOBAL_HIST ? '0 : pred_pc[PC_LSB +: IDX_W];
    assign wr_idx = GLOBAL_HIST ? '0 : res_pc[PC_LSB +: IDX_W];

    always_comb begin
        if (MODE == BP_LAST) begin
            wr_new = last_step(res_taken);
        end else begin
            wr_new = sat2_step(wr_cur, res_taken);
        end
    end

    generate
        if (KEEPS_STATE) begin : g_hist
            bp_hist_table #(
                .IDX_W (IDX_W),
                .DEPTH (DEPTH),
                .INIT  (INIT_STATE)
            ) u_tab (
                .clk    (clk),
                .rst_n  (rst_n),
                .rd_idx (rd_idx),
                .rd_val (rd_slot),
                .wr_en  (res_valid),
                .wr_idx (wr_idx),
                .wr_cur (wr_cur),
                .wr_val (wr_new)
            );
        end else begin : g_nohist
            logic unused_wr;
            assign unused_wr = ^{wr_idx, wr_new, rd_idx};
            assign rd_slot   = INIT_STATE;
            assign wr_cur    = INIT_STATE;
        end
    endgenerate

    bp_decide #(
        .MODE       (MODE),
        .INIT_STATE (INIT_STATE),
        .PC_W       (PC_W)
    ) u_dec (
        .pc     (pred_pc),
        .target (pred_target),
        .slot   (rd_slot),
        .taken  (pred_taken)
    );

    assign miss = res_valid && (res_taken != res_pred);

    bp_stats #(
        .CNT_W (CNT_W)
    ) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .lookup  (pred_valid),
        .miss    (miss),
        .lookups (pred_count),
        .misses  (mispred_count)
    );

endmodule

// File: rtl/bp_check.sv
`timescale 1ns/1ps
module bp_check
    import bp_pkg::*;
#(
    parameter bp_mode_e   MODE        = BP_SAT2,
    parameter bit         GLOBAL_HIST = 1'b0,
    parameter logic [1:0] INIT_STATE  = 2'b01,
    parameter int         PC_W        = 32,
    parameter int         CNT_W       = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             pred_valid,
    input logic [PC_W-1:0]  pred_pc,
    input logic [PC_W-1:0]  pred_target,
    input logic             pred_taken,
    input logic             res_valid,
    input logic             res_taken,
    input logic             res_pred,
    input logic [CNT_W-1:0] pred_count,
    input logic [CNT_W-1:0] mispred_count
);

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pred_count == '0) && (mispred_count == '0));

    assert_lookup_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        pred_valid |=> pred_count == $past(pred_count) + CNT_W'(1));

    assert_lookup_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !pred_valid |=> $stable(pred_count));

    assert_miss_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && (res_taken != res_pred)) |=> mispred_count == $past(mispred_count) + CNT_W'(1));

    assert_miss_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_valid && (res_taken != res_pred)) |=> $stable(mispred_count));

    generate
        if (MODE == BP_FIXED) begin : g_fixed
            assert_fixed_dir_R1: assert property (@(posedge clk) disable iff (!rst_n)
                pred_valid |-> pred_taken == INIT_STATE[1]);
        end
        if (MODE == BP_BTFN) begin : g_btfn
            assert_btfn_dir_R3: assert property (@(posedge clk) disable iff (!rst_n)
                pred_valid |-> pred_taken == (pred_target < pred_pc));
        end
        if ((MODE == BP_LAST) && GLOBAL_HIST) begin : g_last
            assert_last_follow_R2: assert property (@(posedge clk) disable iff (!rst_n)
                res_valid |=> pred_taken == $past(res_taken));
        end
        if ((MODE == BP_SAT2) && GLOBAL_HIST) begin : g_sat
            assert_two_taken_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && res_taken && $past(res_valid && res_taken)) |=> pred_taken);
            assert_two_nottaken_R4: assert property (@(posedge clk) disable iff (!rst_n)
                (res_valid && !res_taken && $past(res_valid && !res_taken)) |=> !pred_taken);
        end
    endgenerate

endmodule

bind branch_dir_pred bp_check #(
    .MODE        (MODE),
    .GLOBAL_HIST (GLOBAL_HIST),
    .INIT_STATE  (INIT_STATE),
    .PC_W        (PC_W),
    .CNT_W       (CNT_W)
) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .pred_valid    (pred_valid),
    .pred_pc       (pred_pc),
    .pred_target   (pred_target),
    .pred_taken    (pred_taken),
    .res_valid     (res_valid),
    .res_taken     (res_taken),
    .res_pred      (res_pred),
    .pred_count    (pred_count),
    .mispred_count (mispred_count)
);

// File: tb/branch_dir_pred_tb.sv
`timescale 1ns/1ps
module branch_dir_pred_tb;
    import bp_pkg::*;

    localparam int PC_W  = 32;
    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             pred_valid = 1'b0;
    logic [PC_W-1:0]  pred_pc = '0;
    logic [PC_W-1:0]  pred_target = '0;
    logic             res_valid = 1'b0;
    logic [PC_W-1:0]  res_pc = '0;
    logic             res_taken = 1'b0;
    logic             res_pred = 1'b0;

    logic             t_dut, t_cntg, t_last, t_fix, t_btfn;
    logic [CNT_W-1:0] c_dut, m_dut, c_cntg, m_cntg_c, c_last, m_last_c, c_fix, m_fix, c_btfn, m_btfn;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    // Counter mode, local, 8 slots, start weak not taken.
    branch_dir_pred #(.MODE(BP_SAT2), .GLOBAL_HIST(1'b0), .INIT_STATE(2'b01), .IDX_W(3)) u_dut (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_target(pred_target),
        .pred_taken(t_dut), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred(res_pred), .pred_count(c_dut), .mispred_count(m_dut));

    branch_dir_pred #(.MODE(BP_SAT2), .GLOBAL_HIST(1'b1), .INIT_STATE(2'b11), .IDX_W(3)) u_cntg (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_target(pred_target),
        .pred_taken(t_cntg), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred(res_pred), .pred_count(c_cntg), .mispred_count(m_cntg_c));

    branch_dir_pred #(.MODE(BP_LAST), .GLOBAL_HIST(1'b1), .INIT_STATE(2'b10), .IDX_W(3)) u_last (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_target(pred_target),
        .pred_taken(t_last), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred(res_pred), .pred_count(c_last), .mispred_count(m_last_c));

    branch_dir_pred #(.MODE(BP_FIXED), .GLOBAL_HIST(1'b0), .INIT_STATE(2'b00), .IDX_W(3)) u_fix (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_target(pred_target),
        .pred_taken(t_fix), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred(res_pred), .pred_count(c_fix), .mispred_count(m_fix));

    branch_dir_pred #(.MODE(BP_BTFN), .GLOBAL_HIST(1'b0), .INIT_STATE(2'b01), .IDX_W(3)) u_btfn (
        .clk(clk), .rst_n(rst_n), .pred_valid(pred_valid), .pred_pc(pred_pc), .pred_target(pred_target),
        .pred_taken(t_btfn), .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_pred(res_pred), .pred_count(c_btfn), .mispred_count(m_btfn));

    // Reference model state
    logic [1:0] ref_loc [8];
    logic [1:0] ref_glob;
    logic       ref_last;
    int         exp_preds = 0;
    int         exp_miss  = 0;

    typedef struct {
        logic e_dut;
        logic e_cntg;
        logic e_last;
        logic e_fix;
        logic e_btfn;
    } exp_t;

    exp_t q[$];

    function automatic logic [1:0] ref_sat(input logic [1:0] v, input logic t);
        if (t)  return (v == 2'd3) ? 2'd3 : v + 2'd1;
        return (v == 2'd0) ? 2'd0 : v - 2'd1;
    endfunction

    task automatic check(input logic act, input logic exp, input string req);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_cnt(input logic [CNT_W-1:0] act, input int exp, input string req);
        n_checks++;
        if (act !== CNT_W'(exp)) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic reset_model();
        for (int i = 0; i < 8; i++) ref_loc[i] = 2'b01;
        ref_glob  = 2'b11;
        ref_last  = 1'b1;
        exp_preds = 0;
        exp_miss  = 0;
    endtask

    // Driver: one cycle of stimulus; expected results are pushed before the model trains.
    task automatic step(input logic pv, input logic [PC_W-1:0] ppc, input logic [PC_W-1:0] ptg,
                        input logic rv, input logic [PC_W-1:0] rpc, input logic rt, input logic rp);
        exp_t e;
        @(negedge clk);
        pred_valid  = pv;
        pred_pc     = ppc;
        pred_target = ptg;
        res_valid   = rv;
        res_pc      = rpc;
        res_taken   = rt;
        res_pred    = rp;
        if (pv) begin
            e.e_dut  = ref_loc[ppc[4:2]][1];
            e.e_cntg = ref_glob[1];
            e.e_last = ref_last;
            e.e_fix  = 1'b0;
            e.e_btfn = (ptg < ppc);
            q.push_back(e);
            exp_preds++;
        end
        if (rv) begin
            ref_loc[rpc[4:2]] = ref_sat(ref_loc[rpc[4:2]], rt);
            ref_glob = ref_sat(ref_glob, rt);
            ref_last = rt;
            if (rt != rp) exp_miss++;
        end
    endtask

    task automatic idle();
        step(1'b0, '0, '0, 1'b0, '0, 1'b0, 1'b0);
    endtask

    // Monitor: pops expected predictions and compares them mid-cycle.
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (rst_n && pred_valid) begin
                if (q.size() == 0) begin
                    n_checks++;
                    n_fail++;
                    $display("FAIL R9: lookup seen with empty scoreboard (got 1 expected 0)");
                end else begin
                    exp_t e;
                    e = q.pop_front();
                    check(t_dut,  e.e_dut,  "R4 R6 R8 local counter");
                    check(t_cntg, e.e_cntg, "R4 R7 global counter");
                    check(t_last, e.e_last, "R2 R7 last outcome");
                    check(t_fix,  e.e_fix,  "R1 R11 fixed");
                    check(t_btfn, e.e_btfn, "R3 R11 target compare");
                end
            end
        end
    end

    // Watchdog
    initial begin
        #400000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [15:0] lfsr;
        reset_model();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R5: counters clear and slots hold INIT_STATE
        check_cnt(c_dut, 0, "R5 lookup count after reset");
        check_cnt(m_dut, 0, "R5 miss count after reset");

        // R5 initial lookups; R3 backward, forward and equal
        step(1'b1, 32'h1000, 32'h1040, 1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 32'h1040, 32'h1000, 1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 32'h1080, 32'h1080, 1'b0, '0, 1'b0, 1'b0);

        // R8: lookup and resolve on the same slot in the same cycle, climbing to saturation (R4)
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 32'h1000, 32'h0F00, 1'b1, 32'h1000, 1'b1, 1'b0);
        end
        // R6: alias slot 0 sees the trained value, slot 1 is untouched
        step(1'b1, 32'h1020, 32'h2000, 1'b0, '0, 1'b0, 1'b0);
        step(1'b1, 32'h1004, 32'h2000, 1'b0, '0, 1'b0, 1'b0);
        // R4: walk down past 00
        for (int i = 0; i < 5; i++) begin
            step(1'b1, 32'h1020, 32'h1000, 1'b1, 32'h1020, 1'b0, 1'b1);
        end
        step(1'b1, 32'h1000, 32'h1000, 1'b0, '0, 1'b0, 1'b0);
        // R11: no resolve, nothing moves
        idle();
        idle();
        step(1'b1, 32'h1000, 32'h1000, 1'b0, '0, 1'b0, 1'b0);

        // Pseudo-random traffic
        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            logic [PC_W-1:0] a, b, r;
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            a = 32'h4000 + {26'd0, lfsr[5:0], 2'b00} - 32'h40;
            b = 32'h4000 + {24'd0, lfsr[15:8]};
            r = 32'h4000 + {26'd0, lfsr[11:6], 2'b00} - 32'h40;
            step(lfsr[0] | lfsr[3], a, b, lfsr[1], r, lfsr[2], lfsr[4]);
        end
        idle();
        idle();
        #1;
        check_cnt(c_dut,  exp_preds, "R9 lookup count");
        check_cnt(c_last, exp_preds, "R9 lookup count global");
        check_cnt(m_dut,  exp_miss,  "R10 miss count");
        check_cnt(m_fix,  exp_miss,  "R10 miss count fixed");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

endmodule